// File: doc/BRIEF.md
# Burst-Coalescing Write Bridge Buffer

This block carries 32-bit writes from a processor-side local port to a bus-master write port on a PCI-style bus. Every transfer is one aligned 32-bit word, and byte enables are always all asserted. The local port reaches three registers through a 2-bit selector: the write queue, the bus target address, and a control register whose low bit turns burst mode on or off. Writes enter a 16-entry, 32-bit queue.

With burst mode on, the queue collects words until 16 are present. It then requests the bus and sends them as one 16-beat burst (64 bytes). The local side can go on filling the queue while that burst drains. With burst mode off, every queued word becomes its own one-beat bus transaction. The bus address advances by one word after each completed beat, so the next transaction starts where the last one ended. Local writes are held off with a wait signal when the queue is full. They are also held off when an address update would disturb work that is still pending.

Top module: `bwb_bridge`

## Requirements
- R1: After reset, bus_req, bus_valid, bus_last and lcl_wait are low, bus_addr is 0, the queue is empty and burst mode is off.
- R2: A local write is taken on a clock edge where lcl_wr_en is high and lcl_wait is low. lcl_sel selects the target: 0 = queue data, 1 = bus address, 2 = control (bit 0 = burst mode). Selector value 3 is ignored: it changes no address, queue content or request.
- R3: Words leave on the bus in the order they were written. The queue holds 16 words. A data write while 16 words are held sees lcl_wait high and is not taken.
- R4: In burst mode, no request is raised while fewer than 16 words are queued. At 16 words, one request carries 16 beats, and bus_last is high only on the 16th beat.
- R5: With burst mode off, each queued word gets its own request of one beat, with bus_last high on that beat.
- R6: bus_req rises in the cycle after the launch condition is seen. bus_valid rises in the cycle after bus_gnt is sampled high while requesting. bus_valid implies bus_req. Both drop in the cycle after the final beat completes, which is a cycle with bus_valid and bus_ready both high.
- R7: While bus_valid is high and bus_ready is low, bus_valid, bus_data and bus_addr hold their values.
- R8: bus_addr rises by 4 after each completed beat. An address write stores lcl_wdata with bits 1:0 cleared.
- R9: An address write waits, with lcl_wait high, until the queue is empty and no transaction is in progress.
- R10: A control write changes the burst mode only once the queue is empty and the bus side is idle. Until then the old mode keeps governing launches.
- R11: Data writes are taken while a burst is in progress. A queue that reaches 16 words again launches the next burst right after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_wr_en | input | 1 | Local write strobe |
| lcl_sel | input | 2 | Local register selector |
| lcl_wdata | input | 32 | Local write data |
| lcl_wait | output | 1 | Local wait state; the write is not taken this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_data | output | 32 | Data of the current beat |
| bus_valid | output | 1 | Beat valid |
| bus_ready | input | 1 | Beat accepted by the target |
| bus_last | output | 1 | Final beat of the transaction |

## Verification
A behavioural queue model is compared with the ports on every cycle. The stimulus covers single-word mode with a few scattered words, which shows that each word gets its own request. A burst-mode fill that stops at 10 words shows that partial fills never reach the bus. A continuous stream of 32 words is written while the first burst drains, which exercises the full-queue wait state and back-to-back bursts. A mode change issued with 5 words pending shows that the switch is deferred until the queue has drained. Grant latency and target-ready stalls vary from cycle to cycle, so the beat-hold and address-step rules are exercised under back-pressure.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } lsel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2
   } bst_e;

   localparam int WORD_BYTES = 4;
   localparam int BURST_BIT  = 0;

endpackage

// File: rtl/bwb_fifo.sv
module bwb_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   initial begin
      assert (DEPTH >= 2) else $error("bwb_fifo: DEPTH must be at least 2");
      assert (W >= 1) else $error("bwb_fifo: W must be positive");
   end

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   // Pointer wrap: a power-of-two depth wraps on overflow, others compare.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
         assign wr_nxt = (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign full  = (count == DEPTH_C);
   assign empty = (count == '0);

endmodule

// File: rtl/bwb_addr.sv
module bwb_addr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   import bwb_pkg::*;

   localparam int LSB = $clog2(WORD_BYTES);

   initial begin
      assert (ADDR_W > LSB) else $error("bwb_addr: ADDR_W too small");
   end

   logic [ADDR_W-LSB-1:0] word_addr;

   always_ff @(posedge clk) begin
      if (!rst_n)     word_addr <= '0;
      else if (load)  word_addr <= load_val[ADDR_W-1:LSB];
      else if (step)  word_addr <= word_addr + 1'b1;
   end

   assign addr = {word_addr, {LSB{1'b0}}};

endmodule

// File: rtl/bwb_seq.sv
module bwb_seq #(
   parameter int DEPTH     = 16,
   parameter int BURST_LEN = 16,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             mode_wr,
   input  logic             mode_val,
   input  logic             bus_gnt,
   input  logic             bus_ready,
   output logic             bus_req,
   output logic             bus_valid,
   output logic             bus_last,
   output logic             beat_done,
   output logic             idle,
   output logic             burst_on
);
   import bwb_pkg::*;

   initial begin
      assert (BURST_LEN >= 1 && BURST_LEN <= DEPTH)
         else $error("bwb_seq: BURST_LEN must be in 1..DEPTH");
   end

   localparam logic [CNT_W-1:0]  FILL_C    = CNT_W'(BURST_LEN);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

   bst_e              st;
   logic [BEAT_W-1:0] beat;
   logic              mode_pend;
   logic              launch;
   logic              final_beat;

   assign launch     = burst_on ? (count >= FILL_C) : (count != '0);
   assign final_beat = burst_on ? (beat == LAST_BEAT) : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         beat <= '0;
      end else begin
         case (st)
            ST_IDLE: if (launch) begin
               st   <= ST_REQ;
               beat <= '0;
            end
            ST_REQ:  if (bus_gnt) st <= ST_XFER;
            ST_XFER: if (bus_ready) begin
               beat <= beat + 1'b1;
               if (final_beat) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Mode changes are staged and applied only when nothing is pending.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_pend <= 1'b0;
         burst_on  <= 1'b0;
      end else begin
         if (mode_wr) mode_pend <= mode_val;
         if (st == ST_IDLE && count == '0) burst_on <= mode_pend;
      end
   end

   assign idle      = (st == ST_IDLE);
   assign bus_req   = (st == ST_REQ) || (st == ST_XFER);
   assign bus_valid = (st == ST_XFER);
   assign bus_last  = bus_valid && final_beat;
   assign beat_done = bus_valid && bus_ready;

endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int DEPTH     = 16,
   parameter int BURST_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lcl_wr_en,
   input  logic [1:0]        lcl_sel,
   input  logic [DATA_W-1:0] lcl_wdata,
   output logic              lcl_wait,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic              bus_last
);
   import bwb_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (DATA_W >= ADDR_W) else $error("bwb_bridge: address must fit the data word");
   end

   logic             is_data, is_addr, is_ctrl, taken;
   logic             q_full, q_empty, beat_done, seq_idle, quiet, burst_on;
   logic [CNT_W-1:0] q_count;

   assign is_data = (lcl_sel == SEL_DATA);
   assign is_addr = (lcl_sel == SEL_ADDR);
   assign is_ctrl = (lcl_sel == SEL_CTRL);
   assign quiet   = seq_idle && q_empty;

   assign lcl_wait = lcl_wr_en && ((is_data && q_full) || (is_addr && !quiet));
   assign taken    = lcl_wr_en && !lcl_wait;

   bwb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (taken && is_data),
      .wdata (lcl_wdata),
      .pop   (beat_done),
      .rdata (bus_data),
      .count (q_count),
      .full  (q_full),
      .empty (q_empty)
   );

   bwb_seq #(.DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (q_count),
      .mode_wr   (taken && is_ctrl),
      .mode_val  (lcl_wdata[BURST_BIT]),
      .bus_gnt   (bus_gnt),
      .bus_ready (bus_ready),
      .bus_req   (bus_req),
      .bus_valid (bus_valid),
      .bus_last  (bus_last),
      .beat_done (beat_done),
      .idle      (seq_idle),
      .burst_on  (burst_on)
   );

   bwb_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (taken && is_addr),
      .load_val (lcl_wdata[ADDR_W-1:0]),
      .step     (beat_done),
      .addr     (bus_addr)
   );

endmodule

// File: rtl/bwb_bridge_chk.sv
module bwb_bridge_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lcl_wr_en,
   input logic [1:0]        lcl_sel,
   input logic [DATA_W-1:0] lcl_wdata,
   input logic              lcl_wait,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic              bus_last
);

   // Shadow occupancy built from port activity only.
   int held;
   logic wr_data_ok, beat_ok;
   assign wr_data_ok = lcl_wr_en && !lcl_wait && (lcl_sel == 2'd0);
   assign beat_ok    = bus_valid && bus_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) held <= 0;
      else        held <= held + (wr_data_ok ? 1 : 0) - (beat_ok ? 1 : 0);
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lcl_wr_en && lcl_sel == 2'd0 && held == DEPTH) |-> lcl_wait);

   assert_valid_has_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> held != 0);

   assert_valid_under_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_req);

   assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && bus_last) |=> !bus_valid);

   assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> $past(bus_valid && bus_ready && bus_last));

   assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_addr)));

   assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && !bus_last) |=> bus_addr == $past(bus_addr) + 4);

   assert_addr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lcl_wr_en && !lcl_wait && lcl_sel == 2'd1)
      |=> bus_addr == {$past(lcl_wdata[ADDR_W-1:2]), 2'b00});

   assert_last_in_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_last |-> bus_valid);

endmodule

bind bwb_bridge bwb_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lcl_wr_en (lcl_wr_en),
   .lcl_sel   (lcl_sel),
   .lcl_wdata (lcl_wdata),
   .lcl_wait  (lcl_wait),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_addr  (bus_addr),
   .bus_data  (bus_data),
   .bus_valid (bus_valid),
   .bus_ready (bus_ready),
   .bus_last  (bus_last)
);

// File: tb/bwb_bridge_tb_top.sv
`timescale 1ns/1ps
module bwb_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lcl_wr_en = 1'b0;
   logic [1:0]  lcl_sel = 2'd0;
   logic [31:0] lcl_wdata = '0;
   logic        lcl_wait;
   logic        bus_req, bus_valid, bus_last;
   logic        bus_gnt = 1'b0, bus_ready = 1'b0;
   logic [31:0] bus_addr, bus_data;

   always #2.5 clk = ~clk;

   bwb_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .lcl_wr_en(lcl_wr_en), .lcl_sel(lcl_sel),
      .lcl_wdata(lcl_wdata), .lcl_wait(lcl_wait), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_last(bus_last)
   );

   int total = 0;
   int bad = 0;
   int req_rises = 0;
   logic prev_req = 1'b0;
   logic finished = 1'b0;
   logic [31:0] wseq = 32'hA000_0000;

   // Reference model
   logic [31:0] mq[$];
   int          m_st = 0;
   int          m_beats = 0;
   int          m_blen = 1;
   logic [31:0] m_addr = '0;
   logic        m_act = 1'b0;
   logic        m_pend = 1'b0;
   logic        m_ie, m_acc;
   int          m_sz;

   function automatic logic model_wait();
      return lcl_wr_en && ((lcl_sel == 2'd0 && mq.size() == 16) ||
                           (lcl_sel == 2'd1 && !(m_st == 0 && mq.size() == 0)));
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         m_st = 0; m_beats = 0; m_blen = 1; m_addr = '0; m_act = 1'b0; m_pend = 1'b0;
      end else begin
         m_ie  = (m_st == 0 && mq.size() == 0);
         m_acc = lcl_wr_en && !model_wait();
         m_sz  = mq.size();
         case (m_st)
            0: if (m_act ? (m_sz >= 16) : (m_sz > 0)) begin
                  m_st = 1; m_blen = m_act ? 16 : 1; m_beats = 0;
               end
            1: if (bus_gnt) m_st = 2;
            default: if (bus_ready) begin
                  void'(mq.pop_front());
                  m_addr = m_addr + 32'd4;
                  m_beats++;
                  if (m_beats == m_blen) m_st = 0;
               end
         endcase
         if (m_ie) m_act = m_pend;
         if (m_acc) begin
            case (lcl_sel)
               2'd0: mq.push_back(lcl_wdata);
               2'd1: m_addr = {lcl_wdata[31:2], 2'b00};
               2'd2: m_pend = lcl_wdata[0];
               default: ;
            endcase
         end
      end
   end

   // Per-cycle comparison, away from the active edge
   always begin
      @(negedge clk);
      #1;
      if (rst_n && !finished) begin
         check((lcl_sel == 2'd1) ? "R9" : "R3", "lcl_wait", {31'd0, lcl_wait}, {31'd0, model_wait()});
         check("R6", "bus_req", {31'd0, bus_req}, {31'd0, m_st != 0});
         check("R6", "bus_valid", {31'd0, bus_valid}, {31'd0, m_st == 2});
         check((m_blen == 16) ? "R4" : "R5", "bus_last", {31'd0, bus_last},
               {31'd0, (m_st == 2) && (m_beats == m_blen - 1)});
         check("R8", "bus_addr", bus_addr, m_addr);
         if (m_st == 2) check("R3 R7", "bus_data", bus_data, mq[0]);
         if (bus_req && !prev_req) req_rises++;
         prev_req = bus_req;
      end
   end

   // Bus target: varying grant latency and ready stalls
   always @(negedge clk) begin
      bus_gnt   <= bus_req && ($urandom % 3 != 0);
      bus_ready <= ($urandom % 4 != 0);
   end

   task automatic lw(input logic [1:0] sel, input logic [31:0] d);
      lcl_wr_en = 1'b1; lcl_sel = sel; lcl_wdata = d;
      #1;
      while (lcl_wait) begin @(negedge clk); #1; end
      @(negedge clk);
      lcl_wr_en = 1'b0;
   endtask

   task automatic push_words(input int n);
      for (int i = 0; i < n; i++) begin
         wseq = wseq + 32'h0001_0003;
         lw(2'd0, wseq);
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         if (m_st == 0 && mq.size() == 0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   int base;

   initial begin
      repeat (4) @(negedge clk);
      #1;
      // R1: reset state
      check("R1", "bus_req", {31'd0, bus_req}, 32'd0);
      check("R1", "bus_valid", {31'd0, bus_valid}, 32'd0);
      check("R1", "bus_last", {31'd0, bus_last}, 32'd0);
      check("R1", "bus_addr", bus_addr, 32'd0);
      check("R1", "lcl_wait", {31'd0, lcl_wait}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 single-word mode, R8 low address bits cleared
      lw(2'd1, 32'h1000_0003);
      #1 check("R8", "loaded address", bus_addr, 32'h1000_0000);
      @(negedge clk);
      base = req_rises;
      push_words(3);
      wait_idle();
      check("R5", "requests for 3 single words", req_rises - base, 3);

      // R9 address write held until drained
      push_words(2);
      lw(2'd1, 32'h2000_0000);
      #1 check("R9", "address after drain", bus_addr, 32'h2000_0000);
      wait_idle();

      // R2 selector 3 ignored
      base = req_rises;
      lw(2'd3, 32'hFFFF_FFFF);
      repeat (6) @(negedge clk);
      #1 check("R2", "address after selector 3", bus_addr, 32'h2000_0000);
      check("R2", "requests after selector 3", req_rises - base, 0);
      @(negedge clk);

      // R4 partial fill in burst mode stays queued
      lw(2'd2, 32'h0000_0001);
      repeat (3) @(negedge clk);
      base = req_rises;
      push_words(10);
      repeat (20) @(negedge clk);
      check("R4", "requests with 10 words queued", req_rises - base, 0);
      // R11 keep writing during the burst, second burst follows
      push_words(22);
      wait_idle();
      check("R11", "requests for 32 words", req_rises - base, 2);
      check("R8", "address after 32 beats", bus_addr, 32'h2000_0080);

      // R10 mode change deferred while words are queued
      base = req_rises;
      push_words(5);
      lw(2'd2, 32'h0000_0000);
      repeat (20) @(negedge clk);
      check("R10", "requests while mode change pending", req_rises - base, 0);
      push_words(11);
      wait_idle();
      push_words(2);
      wait_idle();
      check("R10", "one burst then two singles", req_rises - base, 3);

      finish_run();
   end

endmodule